// File: doc/BRIEF.md
# Serial Audio Frame Generator

This block produces the three-wire serial output that a sound generator feeds to an external floating-point DAC. The wires are a bit clock, a sample latch strobe and a serial data line. Everything runs from one master clock. One sample frame lasts 72 master cycles and is split into 18 bit slots of 4 cycles each. The first 5 slots are padding. They are followed by a 10-bit mantissa, least significant bit first, and then a 3-bit exponent, least significant bit first.

A sample arrives on a parallel input with a valid/ready handshake. The block accepts at most one sample per frame, and only on the first master cycle of the frame. While that frame's padding is sent, the new sample is already held, ready for the data slots. If no sample is offered when the frame starts, the previous sample is sent again. The bit clock is high during the second master cycle of every slot. A receiver therefore shifts each bit in on the rising bit clock, while the data line is in mid-slot. The strobe is high across the last 8 slots, and its falling edge tells the receiver to load the whole word.

Top module: `serial_frame_gen`

## Requirements
- R1: The output pattern repeats every 72 master clock cycles. Cycle 0 is the first cycle after reset is released.
- R2: The data line changes only on the first master cycle of a slot. It then stays at that value for all 4 cycles of the slot.
- R3: The data slots are sent in this order:
  - Slots 0 to 4 send logic 0.
  - Slots 5 to 14 send mantissa bits 0 to 9, in that order.
  - Slots 15 to 17 send exponent bits 0 to 2, in that order.
  - Slot k occupies frame cycles 4k to 4k+3.
- R4: The bit clock is high only on master cycle 1 of each slot (frame cycles 4k+1). This gives one pulse per slot and a 25% duty cycle.
- R5: The latch strobe is high from frame cycle 40 through frame cycle 71, which covers slots 10 to 17 (32 cycles). It is low for the rest of the frame.
- R6: The latch strobe never changes on a cycle where the bit clock is high, or on the cycle right after one.
- R7: `smp_ready` is high only on frame cycle 0, and only while reset is inactive. If `smp_valid` is high on that cycle, the sample on the inputs is captured, and it is the one sent in that frame's data slots. Inputs on every other cycle are ignored.
- R8: If no sample is accepted on frame cycle 0, the frame repeats the sample most recently accepted.
- R9: While `rst_n` is low, the outputs are as follows:
  - The bit clock, strobe, data line and `smp_ready` are all low.
  - The held sample is cleared to zero.
  - The frame restarts at cycle 0 once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | A sample is offered |
| smp_mant | input | 10 | Sample mantissa |
| smp_exp | input | 3 | Sample exponent |
| smp_ready | output | 1 | Sample accepted this cycle if valid |
| bclk_o | output | 1 | Bit clock |
| strobe_o | output | 1 | Sample latch strobe |
| sdata_o | output | 1 | Serial data |

## Verification
Sample capture and the strobe's falling edge happen on the same master cycle, which is frame cycle 0. The new word must not reach the data line while the previous frame's exponent is still being sent. To provoke this, the bench keeps `smp_valid` high and changes the sample on every cycle through the last slots and across the boundary. It then compares the data line cycle by cycle against a model. In that model, only the value present on cycle 0 is used, and it is used only from slot 5 onward.

// File: rtl/sfg_pkg.sv
// Package: shared sample type and field widths for the serial frame generator.
// Assumes: mantissa and exponent widths are fixed by the receiving converter.
package sfg_pkg;
    localparam int MANT_W = 10;
    localparam int EXP_W  = 3;

    typedef struct packed {
        logic [MANT_W-1:0] mant;
        logic [EXP_W-1:0]  expo;
    } sample_t;
endpackage

// File: rtl/sfg_timing.sv
// Module: sfg_timing
// Counts master cycles within a slot and slots within a frame, and drives
// the registered bit clock and latch strobe from the counter values that
// follow the next edge.
// Assumes: CLKS_PER_SLOT >= 2, LATCH_SLOTS <= SLOTS.
module sfg_timing #(
    parameter int SLOTS         = 18,
    parameter int CLKS_PER_SLOT = 4,
    parameter int LATCH_SLOTS   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic [$clog2(SLOTS)-1:0]  slot_q,
    output logic [$clog2(SLOTS)-1:0]  slot_nxt,
    output logic [$clog2(CLKS_PER_SLOT)-1:0] phase_q,
    output logic                      frame_start,
    output logic                      bclk_o,
    output logic                      strobe_o
);
    localparam int SLOT_W      = $clog2(SLOTS);
    localparam int PH_W        = $clog2(CLKS_PER_SLOT);
    localparam int FIRST_LATCH = SLOTS - LATCH_SLOTS;
    localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(SLOTS - 1);
    localparam logic [PH_W-1:0]   LAST_PHASE = PH_W'(CLKS_PER_SLOT - 1);

    logic [PH_W-1:0] phase_nxt;

    // Next counter values: the phase wraps each slot, the slot wraps each frame.
    always_comb begin
        phase_nxt = phase_q + PH_W'(1);
        slot_nxt  = slot_q;
        if (phase_q == LAST_PHASE) begin
            phase_nxt = '0;
            slot_nxt  = (slot_q == LAST_SLOT) ? '0 : slot_q + SLOT_W'(1);
        end
    end

    // Counter and output registers; outputs reflect the state after the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= '0;
            slot_q   <= '0;
            bclk_o   <= 1'b0;
            strobe_o <= 1'b0;
        end else begin
            phase_q  <= phase_nxt;
            slot_q   <= slot_nxt;
            bclk_o   <= (phase_nxt == PH_W'(1));
            strobe_o <= (32'(slot_nxt) >= FIRST_LATCH);
        end
    end

    // First master cycle of a frame, gated off during reset.
    assign frame_start = rst_n && (slot_q == '0) && (phase_q == '0);

    // R1: the last cycle of a frame is followed by cycle 0 of the next.
    p_frame_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == LAST_SLOT && phase_q == LAST_PHASE) |=> (slot_q == '0 && phase_q == '0));

    // R4: each bit clock pulse lasts one master cycle, in phase 1 of a slot.
    p_bclk_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_o |=> !bclk_o);
    p_bclk_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_o |-> (phase_q == PH_W'(1)));

    // R5: the strobe rises only at the start of the first latch slot.
    p_strobe_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_o) |-> (32'(slot_q) == FIRST_LATCH && phase_q == '0));

    // R6: the strobe is steady while the bit clock is high and on the cycle after.
    p_strobe_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_o |=> $stable(strobe_o));
endmodule

// File: rtl/sfg_shifter.sv
// Module: sfg_shifter
// Holds the accepted sample and chooses the bit that goes out in each slot.
// The order is padding, then the mantissa LSB first, then the exponent LSB first.
// Assumes: PAD_SLOTS + MANT_W + EXP_W equals the number of slots per frame.
module sfg_shifter
    import sfg_pkg::*;
#(
    parameter int SLOTS     = 18,
    parameter int PAD_SLOTS = 5,
    parameter int CLKS_PER_SLOT = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  sample_t                  smp_in,
    input  logic [$clog2(SLOTS)-1:0] slot_q,
    input  logic [$clog2(SLOTS)-1:0] slot_nxt,
    input  logic [$clog2(CLKS_PER_SLOT)-1:0] phase_q,
    output logic                     sdata_o
);
    localparam int MANT_BASE = PAD_SLOTS;
    localparam int EXP_BASE  = PAD_SLOTS + MANT_W;

    sample_t word_q;
    logic    bit_nxt;

    // Held sample: replaced only when a sample is accepted at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)    word_q <= '0;
        else if (load) word_q <= smp_in;
    end

    // Bit for the slot after the next edge; padding slots match no field and stay 0.
    always_comb begin
        bit_nxt = 1'b0;
        for (int i = 0; i < MANT_W; i++)
            if (32'(slot_nxt) == MANT_BASE + i) bit_nxt = word_q.mant[i];
        for (int j = 0; j < EXP_W; j++)
            if (32'(slot_nxt) == EXP_BASE + j) bit_nxt = word_q.expo[j];
    end

    // Registered serial data line.
    always_ff @(posedge clk) begin
        if (!rst_n) sdata_o <= 1'b0;
        else        sdata_o <= bit_nxt;
    end

    // R2: the data line holds still after phase 0 of a slot.
    p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != '0) |-> $stable(sdata_o));

    // R3: padding slots carry logic 0.
    p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(slot_q) < PAD_SLOTS) |-> !sdata_o);

    // R7: a load happens only at the start of a frame.
    p_load_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (slot_q == '0 && phase_q == '0));
endmodule

// File: rtl/serial_frame_gen.sv
// Module: serial_frame_gen (top)
// Produces the bit clock, latch strobe and serial data of a floating-point
// audio output frame. It accepts one parallel sample per frame through a
// valid/ready handshake.
// Assumes: a single master clock domain and a synchronous active-low reset.
module serial_frame_gen
    import sfg_pkg::*;
#(
    parameter int PAD_SLOTS     = 5,
    parameter int CLKS_PER_SLOT = 4,
    parameter int LATCH_SLOTS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [MANT_W-1:0] smp_mant,
    input  logic [EXP_W-1:0]  smp_exp,
    output logic              smp_ready,
    output logic              bclk_o,
    output logic              strobe_o,
    output logic              sdata_o
);
    localparam int SLOTS  = PAD_SLOTS + MANT_W + EXP_W;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int PH_W   = $clog2(CLKS_PER_SLOT);

    logic [SLOT_W-1:0] slot_q, slot_nxt;
    logic [PH_W-1:0]   phase_q;
    logic              frame_start;
    sample_t           smp_in;

    assign smp_in    = '{mant: smp_mant, expo: smp_exp};
    assign smp_ready = frame_start;

    sfg_timing #(
        .SLOTS(SLOTS), .CLKS_PER_SLOT(CLKS_PER_SLOT), .LATCH_SLOTS(LATCH_SLOTS)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .slot_q(slot_q), .slot_nxt(slot_nxt),
        .phase_q(phase_q), .frame_start(frame_start),
        .bclk_o(bclk_o), .strobe_o(strobe_o)
    );

    sfg_shifter #(
        .SLOTS(SLOTS), .PAD_SLOTS(PAD_SLOTS), .CLKS_PER_SLOT(CLKS_PER_SLOT)
    ) u_shifter (
        .clk(clk), .rst_n(rst_n), .load(smp_valid && smp_ready), .smp_in(smp_in),
        .slot_q(slot_q), .slot_nxt(slot_nxt), .phase_q(phase_q), .sdata_o(sdata_o)
    );

    // R9: while reset is asserted, nothing is offered and all outputs are low
    // (checked one edge after reset is sampled).
    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |=> (!bclk_o && !strobe_o && !sdata_o));
    p_ready_reset_r9: assert property (@(posedge clk) !rst_n |-> !smp_ready);
endmodule

// File: tb/serial_frame_gen_test.sv
// Bench: behavioural frame model compared with the outputs on every clock.
module serial_frame_gen_test;
    localparam int PERIOD = 10;
    localparam int FRAME  = 72;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [9:0] smp_mant = '0;
    logic [2:0] smp_exp = '0;
    logic       smp_ready, bclk_o, strobe_o, sdata_o;

    int tests = 0;
    int fails = 0;
    int t = 0;             // frame cycle counter of the model
    int held_m = 0;        // model's held mantissa
    int held_e = 0;        // model's held exponent
    bit done = 0;

    serial_frame_gen uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_mant(smp_mant),
        .smp_exp(smp_exp), .smp_ready(smp_ready), .bclk_o(bclk_o),
        .strobe_o(strobe_o), .sdata_o(sdata_o)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic got, input logic expv);
        tests++;
        if (got !== expv) begin
            fails++;
            $display("FAIL %s t=%0d got=%0b exp=%0b", req, t % FRAME, got, expv);
        end
    endtask

    // Model of one cycle: the outputs expected at frame cycle t.
    task automatic check_cycle();
        int f = t % FRAME;
        int s = f / 4;
        int c = f % 4;
        logic d;
        if (s < 5)       d = 1'b0;
        else if (s < 15) d = 1'((held_m >> (s - 5)) & 1);
        else             d = 1'((held_e >> (s - 15)) & 1);
        chk("R7 ready", smp_ready, f == 0);
        chk("R4 R1 bclk", bclk_o, c == 1);
        chk("R5 R6 strobe", strobe_o, s >= 10);
        chk("R2 R3 R8 sdata", sdata_o, d);
    endtask

    // Drive one cycle's inputs after a falling edge, check, and advance the model.
    task automatic step(input logic v, input int m, input int e);
        smp_valid = v;
        smp_mant  = 10'(m);
        smp_exp   = 3'(e);
        #1;
        check_cycle();
        if ((t % FRAME) == 0 && v) begin
            held_m = m & 1023;
            held_e = e & 7;
        end
        t++;
        @(negedge clk);
    endtask

    // Hold reset for n cycles; R9: outputs low during reset, model restarts.
    task automatic do_reset(input int n);
        rst_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R9 ready", smp_ready, 1'b0);
            chk("R9 bclk", bclk_o, 1'b0);
            chk("R9 strobe", strobe_o, 1'b0);
            chk("R9 sdata", sdata_o, 1'b0);
        end
        rst_n = 1'b1;
        t = 0;
        held_m = 0;
        held_e = 0;
    endtask

    initial begin
        @(negedge clk);
        do_reset(3);
        // R8: no sample offered in the first frame, so the cleared word is sent.
        for (int i = 0; i < FRAME; i++) step(1'b0, 0, 0);
        // R3 R7: offer a sample only on cycle 0.
        for (int i = 0; i < FRAME; i++) step(i == 0, 10'h2A5, 3'd5);
        // R8: no offer, so the previous sample repeats.
        for (int i = 0; i < FRAME; i++) step(1'b0, 10'h3FF, 7);
        // R7: valid held high with the data changing every cycle;
        // only cycle 0 counts, which exercises the boundary with the strobe's fall.
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < FRAME; i++) step(1'b1, (k * 311 + i * 37 + 5) & 1023, (k + i) & 7);
        // Extremes: all ones, then all zeros.
        for (int i = 0; i < FRAME; i++) step(1'b1, 1023, 7);
        for (int i = 0; i < FRAME; i++) step(1'b1, 0, 0);
        for (int i = 0; i < FRAME; i++) step(i == 0, 10'h155, 3'd2);
        // R9: reset in mid-frame, then restart from cycle 0 with a cleared word.
        for (int i = 0; i < 45; i++) step(1'b0, 0, 0);
        do_reset(2);
        for (int i = 0; i < FRAME; i++) step(1'b0, 0, 0);
        for (int i = 0; i < FRAME; i++) step(i == 0, 10'h0F3, 3'd6);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule